// File: doc/BRIEF.md
# Reset Supervisor with Cause Flags

This block turns three kinds of reset request into one active-low reset drive of fixed length. The requests are a supply-good level that has already been synchronized, a sampled level of the bidirectional reset pin, and a one-cycle strobe from a watchdog timer. Timing is counted in periods of a slow tick input, nominally one millisecond, so every duration is a whole number of ticks.

Every request loads the same down-counter. That counter holds reset low for `PULSE_TICKS` ticks after the last request ends. A manual press on the reset pin is accepted only after the pin has stayed low for `DEBOUNCE_TICKS` consecutive ticks. While the block drives the pin low itself, the filter is held clear, so the block's own drive cannot trigger a new press.

Two sticky cause flags record why a reset happened. Both can be read through an 8-bit register port, and software clears a flag by writing 0 to its bit. The hardware only sets the flags, and the two flags can be set at the same time.

Top module: `rsv_reset_supervisor`

## Requirements
- R1: After synchronous reset the drive is low (`rst_drive_n_o`=0), the register reads 8'h40 (supply/manual flag set, watchdog flag clear), and the drive releases after exactly `PULSE_TICKS` ticks.
- R2: While `supply_ok_i` is 0, the drive is low from the next clock onward.
- R3: After `supply_ok_i` returns to 1, the drive stays low for exactly `PULSE_TICKS` ticks. It releases in the cycle after the last of those ticks is sampled.
- R4: A pin low held for `DEBOUNCE_TICKS` consecutive ticks asserts the drive two clocks after the accepting tick, for `PULSE_TICKS` ticks. A low that spans fewer ticks has no effect on the drive or the flags.
- R5: A pin low caused by the block's own drive is never accepted as a press. Once the pulse ends with the switch released, the drive stays high.
- R6: A one-cycle `wdt_expire_i` strobe drives reset low from the next clock, for `PULSE_TICKS` ticks counted from that clock.
- R7: A request that arrives during an active pulse restarts the full `PULSE_TICKS` stretch.
- R8: A supply-low or an accepted manual press sets the supply/manual flag at bit 6. A watchdog strobe sets the watchdog flag at bit 7. The two flags can read as set together (8'hC0).
- R9: A register write clears each flag whose bit is written 0 and leaves alone each flag whose bit is written 1. When a set and a clear fall in the same cycle, the set wins. All other register bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Synchronized supply-above-trip level, 1 = good |
| rst_pin_i | input | 1 | Sampled reset pin level, 0 = low |
| wdt_expire_i | input | 1 | One-cycle watchdog timeout strobe |
| tick_i | input | 1 | One-cycle timebase tick |
| reg_wr_i | input | 1 | Write strobe for the cause register |
| reg_wdata_i | input | REG_W | Write data; 0 in a flag bit clears it |
| reg_rdata_o | output | REG_W | Cause register: bit 7 watchdog, bit 6 supply/manual |
| rst_drive_n_o | output | 1 | Open-drain reset drive, 0 = pull pin low |

## Verification
The stretch is driven by each source on its own, by a supply dip with both flags pending, and by a watchdog strobe that lands halfway through a running pulse. Counting the ticks up to release separates a correct reload from a counter that only extends or that ignores the new request. The pin is driven with a glitch one tick too short, a press held long enough to be accepted, and the block's own drive fed back through the pin. These cases separate proper filtering from acceptance on a raw level, and from a self-sustaining loop. Register writes with mixed 0/1 patterns, and a clear in the same cycle as a set, show which bit each write touches and which operation has priority.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int REG_W   = 8;
  localparam int PWR_BIT = 6;
  localparam int WDT_BIT = 7;
  localparam int NFLAG   = 2;

  // flag index order inside the flag bank
  typedef enum logic [0:0] {
    FLG_PWR = 1'b0,
    FLG_WDT = 1'b1
  } flag_idx_e;

  typedef struct packed {
    logic pwr_low;
    logic manual;
    logic watchdog;
  } req_t;
endpackage

// File: rtl/rsv_debounce.sv
module rsv_debounce #(
  parameter int DEBOUNCE_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic pin_i,
  input  logic mask_i,
  output logic accept_o
);
  localparam int DW = $clog2(DEBOUNCE_TICKS + 1);
  localparam logic [DW-1:0] LAST = DW'(DEBOUNCE_TICKS - 1);

  logic [DW-1:0] cnt_q;
  logic          acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else if (pin_i || mask_i) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        acc_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= 1'b0;
      end
    end else begin
      acc_q <= 1'b0;
    end
  end

  assign accept_o = acc_q;

  // R5
  no_self_trigger_chk: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> ($past(!mask_i) && $past(!pin_i)));
endmodule

// File: rtl/rsv_stretch.sv
module rsv_stretch #(
  parameter int PULSE_TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic req_i,
  output logic active_o
);
  localparam int CW = $clog2(PULSE_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(PULSE_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q;

  always_comb begin
    cnt_d = cnt_q;
    if (req_i)
      cnt_d = FULL;
    else if (tick_i && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= FULL;
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= (cnt_d != '0);
    end
  end

  assign active_o = act_q;

  // R2
  req_asserts_chk: assert property (@(posedge clk) disable iff (rst)
    req_i |=> active_o);
  // R3
  release_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active_o) |-> ($past(tick_i) && $past(!req_i)));
endmodule

// File: rtl/rsv_flags.sv
module rsv_flags
  import rsv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [NFLAG-1:0] flag_o
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam int POS = (i == int'(FLG_PWR)) ? PWR_BIT : WDT_BIT;
    localparam logic RST_VAL = (i == int'(FLG_PWR));
    logic q;

    always_ff @(posedge clk) begin
      if (rst)
        q <= RST_VAL;
      else if (set_i[i])
        q <= 1'b1;
      else if (wr_i && !wdata_i[POS])
        q <= 1'b0;
    end

    assign flag_o[i] = q;

    // R9
    clear_by_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_i && !wdata_i[POS] && !set_i[i]) |=> !flag_o[i]);
    // R9
    one_keeps_chk: assert property (@(posedge clk) disable iff (rst)
      (!set_i[i] && !(wr_i && !wdata_i[POS])) |=> $stable(flag_o[i]));
  end
endmodule

// File: rtl/rsv_reset_supervisor.sv
module rsv_reset_supervisor
  import rsv_pkg::*;
#(
  parameter int PULSE_TICKS    = 100,
  parameter int DEBOUNCE_TICKS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             supply_ok_i,
  input  logic             rst_pin_i,
  input  logic             wdt_expire_i,
  input  logic             tick_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             rst_drive_n_o
);
  req_t             req;
  logic             active;
  logic             man_accept;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] flags;

  rsv_debounce #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_deb (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .pin_i    (rst_pin_i),
    .mask_i   (active),
    .accept_o (man_accept)
  );

  always_comb begin
    req.pwr_low  = !supply_ok_i;
    req.manual   = man_accept;
    req.watchdog = wdt_expire_i;
  end

  rsv_stretch #(.PULSE_TICKS(PULSE_TICKS)) u_str (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .req_i    (|req),
    .active_o (active)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_PWR] = req.pwr_low | req.manual;
    set_vec[FLG_WDT] = req.watchdog;
  end

  rsv_flags u_flg (
    .clk     (clk),
    .rst     (rst),
    .set_i   (set_vec),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .flag_o  (flags)
  );

  always_comb begin
    reg_rdata_o          = '0;
    reg_rdata_o[PWR_BIT] = flags[FLG_PWR];
    reg_rdata_o[WDT_BIT] = flags[FLG_WDT];
  end

  assign rst_drive_n_o = !active;

  // R8
  wdt_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_expire_i |=> (reg_rdata_o[WDT_BIT] && !rst_drive_n_o));
  // R8
  pwr_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> (reg_rdata_o[PWR_BIT] && !rst_drive_n_o));
endmodule

// File: tb/sim_rsv_reset_supervisor.sv
module sim_rsv_reset_supervisor;
  localparam int P  = 12;
  localparam int D  = 4;
  localparam int TP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup = 1'b1;
  logic pin = 1'b1;
  logic wdt = 1'b0;
  logic tick = 1'b0;
  logic wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic drive_n;
  logic sw_low = 1'b0;

  always #2 clk = ~clk;

  rsv_reset_supervisor #(.PULSE_TICKS(P), .DEBOUNCE_TICKS(D)) u0 (
    .clk(clk), .rst(rst), .supply_ok_i(sup), .rst_pin_i(pin),
    .wdt_expire_i(wdt), .tick_i(tick), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .rst_drive_n_o(drive_n)
  );

  int checks = 0, fails = 0, tick_seen = 0, tdiv = 0;
  string phase = "R1";
  bit done = 0;

  // timebase and pin level (switch or own drive pulls low)
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TP;
    tick = (tdiv == 0);
    #1 pin = sw_low ? 1'b0 : drive_n;
  end

  // behavioural reference model
  int m_cnt = P, m_deb = 0;
  bit m_act = 1, m_acc = 0, m_fp = 1, m_fw = 0;
  always @(posedge clk) begin
    bit req, acc_n, sp, sw;
    if (rst) begin
      m_cnt = P; m_act = 1; m_deb = 0; m_acc = 0; m_fp = 1; m_fw = 0;
    end else begin
      tick_seen += tick;
      req = !sup || wdt || m_acc;
      sp = !sup || m_acc;
      sw = wdt;
      acc_n = 0;
      if (pin || m_act) m_deb = 0;
      else if (tick) begin
        if (m_deb == D - 1) begin acc_n = 1; m_deb = 0; end
        else m_deb++;
      end
      m_acc = acc_n;
      if (req) m_cnt = P;
      else if (tick && m_cnt > 0) m_cnt--;
      m_act = (m_cnt != 0);
      if (sp) m_fp = 1; else if (wr && !wdata[6]) m_fp = 0;
      if (sw) m_fw = 1; else if (wr && !wdata[7]) m_fw = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(drive_n == !m_act, {phase, " drive"}, drive_n, !m_act);
      check(rdata == {m_fw, m_fp, 6'b0}, {phase, " flags"}, rdata, {m_fw, m_fp, 6'b0});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 5000 && drive_n == 1'b0; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic wdt_pulse();
    wdt = 1'b1;
    @(negedge clk);
    wdt = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int t0;
    cyc(3);
    rst = 1'b0;
    t0 = tick_seen;
    check(drive_n == 1'b0, "R1 reset drive", drive_n, 0);
    check(rdata == 8'h40, "R1 reset flags", rdata, 8'h40);
    wait_release();
    check(tick_seen - t0 == P, "R1 pulse ticks", tick_seen - t0, P);

    phase = "R9";
    reg_write(8'hFF);
    check(rdata == 8'h40, "R9 ones keep", rdata, 8'h40);
    reg_write(8'hBF);
    check(rdata == 8'h00, "R9 clear pwr", rdata, 8'h00);

    phase = "R6";
    wdt_pulse();
    t0 = tick_seen;
    check(drive_n == 1'b0, "R6 wdt drive", drive_n, 0);
    check(rdata == 8'h80, "R8 wdt flag", rdata, 8'h80);
    wait_release();
    check(tick_seen - t0 == P, "R6 pulse ticks", tick_seen - t0, P);

    phase = "R2";
    sup = 1'b0;
    cyc(1);
    for (int i = 0; i < 30; i++) begin
      if (drive_n != 1'b0) check(0, "R2 held low", drive_n, 0);
      cyc(1);
    end
    check(rdata == 8'hC0, "R8 both flags", rdata, 8'hC0);
    phase = "R3";
    sup = 1'b1;
    t0 = tick_seen;
    wait_release();
    check(tick_seen - t0 == P, "R3 pulse ticks", tick_seen - t0, P);

    phase = "R9";
    reg_write(8'h7F);
    check(rdata == 8'h40, "R9 clear wdt only", rdata, 8'h40);
    reg_write(8'hBF);
    check(rdata == 8'h00, "R9 clear pwr", rdata, 8'h00);
    sup = 1'b0; wr = 1'b1; wdata = 8'h00;
    @(negedge clk);
    wr = 1'b0; sup = 1'b1;
    check(rdata == 8'h40, "R9 set wins", rdata, 8'h40);
    wait_release();
    reg_write(8'h00);

    phase = "R7";
    wdt_pulse();
    cyc(6 * TP);
    wdt_pulse();
    t0 = tick_seen;
    wait_release();
    check(tick_seen - t0 == P, "R7 restart ticks", tick_seen - t0, P);
    reg_write(8'h00);

    phase = "R4";
    sw_low = 1'b1;
    cyc((D - 1) * TP - 1);
    sw_low = 1'b0;
    cyc(3 * TP);
    check(drive_n == 1'b1, "R4 glitch rejected", drive_n, 1);
    check(rdata == 8'h00, "R4 glitch no flag", rdata, 8'h00);
    sw_low = 1'b1;
    t0 = tick_seen;
    for (int i = 0; i < 500 && drive_n == 1'b1; i++) @(negedge clk);
    check(tick_seen - t0 == D, "R4 accept ticks", tick_seen - t0, D);
    cyc(2);
    sw_low = 1'b0;
    wait_release();
    check(rdata == 8'h40, "R8 manual flag", rdata, 8'h40);

    phase = "R5";
    cyc(3 * D * TP);
    check(drive_n == 1'b1, "R5 no self retrigger", drive_n, 1);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    done = 1;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end
endmodule